// File: doc/BRIEF.md
# Clause 45 MDIO Management Master

This block gives a host a simple register pair for reaching PHY registers over an IEEE 802.3 Clause 45 management bus. Software first loads the address register with the target register number, the port address and the device address. It then writes the command register with an operation code, the write data, a bus speed select and a set busy bit. From that single write the block runs the whole bus sequence. It drives MDC, shifts frames out on a tri-stateable data line and collects the PHY's answer on reads.

Busy stays set while the bus is in use. It drops on the same clock edge that completes the last frame. For read-type operations, the low half of the command register holds the returned word from that same edge onward. An optional flag skips the address frame, so a data frame can go straight to the PHY's current register pointer, for example when stepping through registers with post-read-increment.

Top module: `mdio_c45_master`

## Requirements
- R1: The address register (host_sel=0) stores the register address in bits 15:0, the port address in 20:16 and the device address in 25:21, and reads back with the other bits zero.
- R2: The command register (host_sel=1) holds write data in 15:0, the operation in 17:16 (0 none, 1 write, 2 read with post-increment, 3 read), the skip flag in 18, the speed select in 21:19 and busy in 22. Bits 31:23 read as zero. A write with bit 22 set and a non-zero operation starts a transfer, and busy reads 1 from the next cycle on.
- R3: Each frame is 32 ones, then 00, then a 2-bit opcode, then 5-bit port, 5-bit device, turnaround 10 and 16 data bits, all sent MSB first. Without the skip flag an address frame carrying the register address comes before the data frame.
- R4: Frame opcodes are 00 for the address frame, 01 for write, 11 for read and 10 for post-read-increment. A write's data frame carries the command's write data.
- R5: In read-type data frames the line is released (mdio_oe=0) for the turnaround and the 16 data bits. The bits sampled at those 16 MDC rises appear in command bits 15:0 once busy clears.
- R6: Speed select 0..7 gives an MDC period of 8, 16, 32, 64, 96, 128, 192 or 256 clocks, with equal high and low times. Busy lasts exactly frames×64×period cycles. MDC rests low when idle.
- R7: With the skip flag set only the data frame is sent (64 bits).
- R8: A command write while busy changes nothing. Later address register writes do not affect a transfer in flight.
- R9: A command write with operation 0 or with busy clear only stores its fields and starts no bus activity.
- R10: After reset both registers read zero, MDC is low and the line is not driven.
- R11: While a transfer runs, the driven bit changes only on MDC falling edges, and the PHY's bit is sampled on MDC rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_we | input | 1 | Host write strobe |
| host_sel | input | 1 | Register select: 0 address, 1 command |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data of the selected register (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input value |

## Verification
Busy is due on the edge that takes the command write. It then stays high for exactly frames×64×period clocks. The bench counts those cycles at falling clock edges and compares the count with the figure for the chosen speed. The bench records the line at each MDC rise and rebuilds whole frames from those samples, so frame contents are judged bit by bit and not at guessed cycle offsets. The PHY model switches its bit right after each MDC rise, and the block samples on the edge that raises MDC. Read data and cleared busy therefore appear together and are checked only after busy is seen low.

// File: rtl/mdio_pkg.sv
// Shared definitions for the Clause 45 management master.
// Assumes frames of fixed length with a full 32-bit preamble.
package mdio_pkg;

    typedef enum logic [1:0] {
        OP_NONE   = 2'd0,
        OP_WRITE  = 2'd1,
        OP_RD_INC = 2'd2,
        OP_READ   = 2'd3
    } host_op_e;

    localparam int FRAME_BITS = 64;
    localparam int TA_POS     = 46;
    localparam int DATA_POS   = 48;

    // Half MDC period in system clocks for each speed select value.
    function automatic logic [7:0] half_period(input logic [2:0] sel);
        case (sel)
            3'd0:    return 8'd4;
            3'd1:    return 8'd8;
            3'd2:    return 8'd16;
            3'd3:    return 8'd32;
            3'd4:    return 8'd48;
            3'd5:    return 8'd64;
            3'd6:    return 8'd96;
            default: return 8'd128;
        endcase
    endfunction

    // Opcode placed on the wire for a host operation.
    function automatic logic [1:0] wire_op(input host_op_e op);
        case (op)
            OP_WRITE:  return 2'b01;
            OP_READ:   return 2'b11;
            OP_RD_INC: return 2'b10;
            default:   return 2'b00;
        endcase
    endfunction

    // Complete outgoing frame, MSB sent first.
    function automatic logic [FRAME_BITS-1:0] make_frame(input logic [1:0] op,
            input logic [4:0] prt, input logic [4:0] dev, input logic [15:0] val);
        return {32'hFFFF_FFFF, 2'b00, op, prt, dev, 2'b10, val};
    endfunction

endpackage

// File: rtl/mdio_clk_gen.sv
// MDC generator: while run is high it toggles mdc every half period
// chosen by sel, and flags the cycle before each edge. Assumes sel is
// held stable for the whole time run is high. MDC rests low.
module mdio_clk_gen #(
    parameter int CNT_W = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [2:0] sel,
    output logic       mdc,
    output logic       rise,
    output logic       fall
);
    import mdio_pkg::*;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] half;
    logic             at_lim;

    // Half period for the selected speed.
    assign half   = CNT_W'(half_period(sel));
    assign at_lim = run && (cnt == half - 1'b1);
    assign rise   = at_lim && !mdc;
    assign fall   = at_lim && mdc;

    // Count each half period and toggle mdc at its end.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (at_lim) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    a_r6_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !mdc);

endmodule

// File: rtl/mdio_frame_seq.sv
// Frame sequencer: on start it latches the addresses and data, then
// shifts out an optional address frame and a data frame. It advances
// one bit per MDC fall and captures read data on MDC rises. Assumes
// rise/fall come from mdio_clk_gen, which runs while active is high.
module mdio_frame_seq (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                skip_addr,
    input  mdio_pkg::host_op_e  op,
    input  logic [4:0]          prtad,
    input  logic [4:0]          devad,
    input  logic [15:0]         regad,
    input  logic [15:0]         wdata,
    input  logic                rise,
    input  logic                fall,
    input  logic                mdio_i,
    output logic                active,
    output logic                done,
    output logic [15:0]         rdata,
    output logic                mdio_o,
    output logic                mdio_oe
);
    import mdio_pkg::*;

    localparam int IDX_W = $clog2(FRAME_BITS);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAME_BITS - 1);

    logic [FRAME_BITS-1:0] shreg;
    logic [IDX_W-1:0]      bitidx;
    logic                  in_data;
    logic [1:0]            op_q;
    logic [4:0]            prt_q, dev_q;
    logic [15:0]           wdata_q;
    logic                  rd_type;
    logic                  released;

    assign rd_type  = op_q[1];
    assign released = in_data && rd_type && (bitidx >= IDX_W'(TA_POS));
    assign done     = active && fall && in_data && (bitidx == LAST);
    assign mdio_oe  = active && !released;
    assign mdio_o   = mdio_oe ? shreg[FRAME_BITS-1] : 1'b0;

    // Load frames and step through the bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            in_data <= 1'b0;
            shreg   <= '0;
            bitidx  <= '0;
            op_q    <= 2'b00;
            prt_q   <= '0;
            dev_q   <= '0;
            wdata_q <= '0;
        end else if (start && !active) begin
            active  <= 1'b1;
            in_data <= skip_addr;
            bitidx  <= '0;
            op_q    <= wire_op(op);
            prt_q   <= prtad;
            dev_q   <= devad;
            wdata_q <= wdata;
            shreg   <= skip_addr ? make_frame(wire_op(op), prtad, devad, wdata)
                                 : make_frame(2'b00, prtad, devad, regad);
        end else if (active && fall) begin
            if (bitidx == LAST) begin
                if (!in_data) begin
                    in_data <= 1'b1;
                    bitidx  <= '0;
                    shreg   <= make_frame(op_q, prt_q, dev_q, wdata_q);
                end else begin
                    active <= 1'b0;
                end
            end else begin
                shreg  <= shreg << 1;
                bitidx <= bitidx + 1'b1;
            end
        end
    end

    // Shift in read data on MDC rises during the data phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (active && rise && in_data && rd_type &&
                     bitidx >= IDX_W'(DATA_POS)) begin
            rdata <= {rdata[14:0], mdio_i};
        end
    end

    a_r11_tx_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(active) && active && !$stable(shreg[FRAME_BITS-1])) |-> $past(fall));

endmodule

// File: rtl/mdio_c45_master.sv
// Top: host address/command registers around the MDC generator and
// frame sequencer. Busy is the sequencer's active flag. Command writes
// are dropped while busy. Address writes are taken at any time and
// latched by the sequencer only at command start.
module mdio_c45_master #(
    parameter int CNT_W = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_we,
    input  logic        host_sel,
    input  logic [31:0] host_wdata,
    output logic [31:0] host_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    import mdio_pkg::*;

    logic [15:0] a_reg;
    logic [4:0]  a_prt, a_dev;
    logic [15:0] c_data;
    host_op_e    c_op;
    logic        c_skip;
    logic [2:0]  c_sel;
    logic        busy, seq_done, start, cmd_wr;
    logic        tick_rise, tick_fall;
    logic [15:0] seq_rdata;

    assign cmd_wr = host_we && host_sel && !busy;
    assign start  = cmd_wr && host_wdata[22] && (host_wdata[17:16] != 2'd0);

    // Host register writes and read data return.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_reg  <= '0;
            a_prt  <= '0;
            a_dev  <= '0;
            c_data <= '0;
            c_op   <= OP_NONE;
            c_skip <= 1'b0;
            c_sel  <= '0;
        end else begin
            if (host_we && !host_sel) begin
                a_reg <= host_wdata[15:0];
                a_prt <= host_wdata[20:16];
                a_dev <= host_wdata[25:21];
            end
            if (cmd_wr) begin
                c_data <= host_wdata[15:0];
                c_op   <= host_op_e'(host_wdata[17:16]);
                c_skip <= host_wdata[18];
                c_sel  <= host_wdata[21:19];
            end else if (seq_done && c_op[1]) begin
                c_data <= seq_rdata;
            end
        end
    end

    // Register read mux.
    always_comb begin
        if (host_sel)
            host_rdata = {9'd0, busy, c_sel, c_skip, c_op, c_data};
        else
            host_rdata = {6'd0, a_dev, a_prt, a_reg};
    end

    mdio_clk_gen #(.CNT_W(CNT_W)) u_clk (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (busy),
        .sel  (c_sel),
        .mdc  (mdc),
        .rise (tick_rise),
        .fall (tick_fall)
    );

    mdio_frame_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .skip_addr(host_wdata[18]),
        .op       (host_op_e'(host_wdata[17:16])),
        .prtad    (a_prt),
        .devad    (a_dev),
        .regad    (a_reg),
        .wdata    (host_wdata[15:0]),
        .rise     (tick_rise),
        .fall     (tick_fall),
        .mdio_i   (mdio_i),
        .active   (busy),
        .done     (seq_done),
        .rdata    (seq_rdata),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe)
    );

    a_r2_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);

    a_r8_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && host_we && host_sel) |=> ($stable(c_sel) && $stable(c_op) && $stable(c_skip)));

    a_r10_no_drive_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdio_oe && !mdc));

endmodule

// File: tb/sim_mdio_c45_master.sv
// Directed bench: a PHY model returns read data; every frame is rebuilt
// from line samples taken at MDC rises.
module sim_mdio_c45_master;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic        host_sel = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    int          bitcnt = 0;
    logic        seen_o  [0:127];
    logic        seen_oe [0:127];
    int          data_base = 0;
    logic [15:0] phy_word = '0;
    int hi_run = 0, lo_run = 0, last_hi = 0, last_lo = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mdio_c45_master u0 (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    // Line monitor: one sample per MDC rise.
    always @(posedge mdc) begin
        if (bitcnt < 128) begin
            seen_o[bitcnt]  = mdio_o;
            seen_oe[bitcnt] = mdio_oe;
        end
        bitcnt = bitcnt + 1;
    end

    // PHY model: drives data bits of the read frame, else pulled high.
    always @* begin
        int k;
        k = bitcnt - data_base;
        if (k >= 48 && k < 64) mdio_i = phy_word[63-k];
        else mdio_i = 1'b1;
    end

    // MDC high/low run lengths in clocks.
    always @(negedge clk) begin
        if (mdc) begin
            if (lo_run > 0) last_lo = lo_run;
            lo_run = 0;
            hi_run = hi_run + 1;
        end else begin
            if (hi_run > 0) last_hi = hi_run;
            hi_run = 0;
            lo_run = lo_run + 1;
        end
    end

    function automatic logic [63:0] exp_frame(logic [1:0] op, logic [4:0] p,
                                              logic [4:0] d, logic [15:0] v);
        logic [63:0] f;
        f = '1;
        f[31:30] = 2'b00;
        f[29:28] = op;
        f[27:23] = p;
        f[22:18] = d;
        f[17:16] = 2'b10;
        f[15:0]  = v;
        return f;
    endfunction

    function automatic logic [63:0] got_frame(int base);
        logic [63:0] g;
        for (int i = 0; i < 64; i++) g[63-i] = seen_o[base+i];
        return g;
    endfunction

    function automatic logic [63:0] got_oe(int base);
        logic [63:0] g;
        for (int i = 0; i < 64; i++) g[63-i] = seen_oe[base+i];
        return g;
    endfunction

    task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic host_write(logic sel, logic [31:0] d);
        @(negedge clk);
        host_sel = sel; host_wdata = d; host_we = 1'b1;
        @(negedge clk);
        host_we = 1'b0; host_sel = 1'b1;
    endtask

    task automatic host_read(logic sel, output logic [31:0] d);
        host_sel = sel;
        #1 d = host_rdata;
        host_sel = 1'b1;
    endtask

    function automatic logic [31:0] cmd_word(logic [2:0] sel, logic skip,
                                             logic [1:0] op, logic [15:0] v);
        return {9'd0, 1'b1, sel, skip, op, v};
    endfunction

    // Launch a command and count the cycles busy stays high.
    task automatic run_cmd(logic [31:0] c, output int cyc);
        bitcnt = 0;
        host_write(1'b1, c);
        cyc = 0;
        host_sel = 1'b1;
        #1;
        while (host_rdata[22]) begin
            cyc++;
            @(negedge clk);
            #1;
        end
    endtask

    task automatic t_reset;
        logic [31:0] r;
        host_read(1'b0, r); check("R10 addr reg after reset", r, 0);
        host_read(1'b1, r); check("R10 cmd reg after reset", r, 0);
        check("R10 mdc/oe after reset", {mdc, mdio_oe}, 0);
    endtask

    task automatic t_addr_reg;
        logic [31:0] r;
        host_write(1'b0, 32'hFFFF_FFFF);
        host_read(1'b0, r);
        check("R1 address reg field mask", r, 32'h03FF_FFFF);
        host_write(1'b0, {6'd0, 5'h1E, 5'h01, 16'hA55A});
        host_read(1'b0, r);
        check("R1 address reg fields", r, {6'd0, 5'h1E, 5'h01, 16'hA55A});
    endtask

    task automatic t_write;
        int cyc; logic [31:0] r;
        data_base = 64;
        run_cmd(cmd_word(3'd0, 1'b0, 2'd1, 16'h1234), cyc);
        check("R6 busy cycles div8 two frames", cyc, 128*8);
        check("R3 address frame (R11 rise samples)", got_frame(0), exp_frame(2'b00, 5'h01, 5'h1E, 16'hA55A));
        check("R4 write data frame", got_frame(64), exp_frame(2'b01, 5'h01, 5'h1E, 16'h1234));
        check("R3 driven throughout write", {got_oe(0), got_oe(64)}, {64'h0, 64'h0} | '1);
        check("R6 mdc high time div8", last_hi, 4);
        check("R6 mdc low time div8", last_lo, 4);
        host_read(1'b1, r);
        check("R2 cmd readback after write", r, {9'd0, 1'b0, 3'd0, 1'b0, 2'd1, 16'h1234});
    endtask

    task automatic t_read;
        int cyc; logic [31:0] r; logic [63:0] m;
        m = {{46{1'b1}}, 18'd0};
        data_base = 64; phy_word = 16'hC3A5;
        run_cmd(cmd_word(3'd2, 1'b0, 2'd3, 16'h0000), cyc);
        check("R6 busy cycles div32 two frames", cyc, 128*32);
        check("R4 read frame header", got_frame(64) & m, exp_frame(2'b11, 5'h01, 5'h1E, 16'h0) & m);
        check("R5 line released in turnaround/data", got_oe(64), m);
        host_read(1'b1, r);
        check("R5 read data returned", r, {9'd0, 1'b0, 3'd2, 1'b0, 2'd3, 16'hC3A5});
    endtask

    task automatic t_skip_postread;
        int cyc; logic [31:0] r; logic [63:0] m;
        m = {{46{1'b1}}, 18'd0};
        data_base = 0; phy_word = 16'h0F0F;
        run_cmd(cmd_word(3'd4, 1'b1, 2'd2, 16'h0000), cyc);
        check("R7 single frame at div96", cyc, 64*96);
        check("R6 mdc high time div96", last_hi, 48);
        check("R7 first frame is post-read frame", got_frame(0) & m, exp_frame(2'b10, 5'h01, 5'h1E, 16'h0) & m);
        check("R7 no second frame", bitcnt, 64);
        host_read(1'b1, r);
        check("R5 post-read data returned", r[15:0], 16'h0F0F);
    endtask

    task automatic t_busy_ignore;
        int cyc; logic [31:0] r;
        data_base = 64;
        bitcnt = 0;
        host_write(1'b1, cmd_word(3'd7, 1'b0, 2'd1, 16'hBEEF));
        repeat (50) @(negedge clk);
        host_write(1'b1, cmd_word(3'd0, 1'b1, 2'd3, 16'h0001));
        host_write(1'b0, {6'd0, 5'h03, 5'h07, 16'h0042});
        host_read(1'b1, r);
        check("R8 fields unchanged during busy", r, {9'd0, 1'b1, 3'd7, 1'b0, 2'd1, 16'hBEEF});
        cyc = 0;
        #1;
        while (host_rdata[22]) begin cyc++; @(negedge clk); #1; end
        check("R8 transfer length unchanged div256", cyc + 54, 128*256);
        check("R8 address frame uses start-time address", got_frame(0), exp_frame(2'b00, 5'h01, 5'h1E, 16'hA55A));
        check("R8 data frame unchanged", got_frame(64), exp_frame(2'b01, 5'h01, 5'h1E, 16'hBEEF));
        host_read(1'b0, r);
        check("R1 address reg takes write during busy", r, {6'd0, 5'h03, 5'h07, 16'h0042});
    endtask

    task automatic t_no_launch;
        logic [31:0] r;
        bitcnt = 0;
        host_write(1'b1, cmd_word(3'd1, 1'b0, 2'd0, 16'h5555));
        host_read(1'b1, r);
        check("R9 op 0 stores fields, no busy", r, {9'd0, 1'b0, 3'd1, 1'b0, 2'd0, 16'h5555});
        host_write(1'b1, {9'd0, 1'b0, 3'd1, 1'b0, 2'd1, 16'h7777});
        host_read(1'b1, r);
        check("R9 busy clear stores fields, no busy", r, {9'd0, 1'b0, 3'd1, 1'b0, 2'd1, 16'h7777});
        repeat (100) @(negedge clk);
        check("R9 no bus activity", {bitcnt[7:0], mdc, mdio_oe}, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_addr_reg();
        t_write();
        t_read();
        t_skip_postread();
        t_busy_ignore();
        t_no_launch();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 190000);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule